// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns a pair of 24-bit two's complement samples into a single serial data line, left channel first and most significant bit first. It frames the stream either left-justified, with the first data bit in the first bit slot of a half-frame, or in I2S style, with the first data bit delayed by one bit slot. The block is used at the edge of an audio converter or processor. It either generates the bit clock and frame clock itself, or follows clocks supplied from outside.

In master mode the block derives both clocks from the master clock. A two-bit speed select sets the frame clock to 256, 128 or 64 master-clock periods and the bit clock to 4, 2 or 1 master-clock periods. The bit clock therefore runs at 64 periods per frame. An optional prescaler halves the master clock before any of this division. The core runs on `clk2x`, a clock at twice the master-clock rate, so a bit clock equal to the master clock can still be produced from registers.

In slave mode the bit clock and frame clock come in as inputs and are sampled by the core clock. In both modes one shared slot shifter produces the data. A new sample pair is taken at the start of every left half-frame.

Top module: `aud_serial_tx`

## Requirements
- R1: While `rstN` is low, and on its release, `sdata`, `bclkOut` and `lrckOut` are 0.
- R2: In master mode the period of `lrckOut` is 256, 128 or 64 master-clock periods for `speedSel` 00, 01 or 10 respectively, where one master-clock period is two `clk2x` cycles. Code 11 behaves exactly like 00.
- R3: In master mode the period of `bclkOut` is 4, 2 or 1 master-clock periods for the same three codes (11 behaves as 00). Every transition of `lrckOut` coincides with a falling edge of `bclkOut`, and each half-frame holds 32 bit-clock periods.
- R4: When `mdivEn` is 1 in master mode, the master clock is halved first, so both clock periods of R2 and R3 double.
- R5: `sdata` changes only following a falling edge of the bit clock in use. Each channel word is sent as 24 bits, most significant bit first.
- R6: With `fmtI2s`=0, the left word is sent while the frame clock is high and the right word while it is low. The MSB occupies slot 0, which is the first bit-clock period after the frame-clock edge.
- R7: With `fmtI2s`=1, the left word is sent while the frame clock is low and the right word while it is high. The MSB occupies slot 1 of the half-frame.
- R8: Every slot of a half-frame outside the 24 data slots carries 0.
- R9: `leftIn` and `rightIn` are sampled together at the bit-clock falling edge that starts a left half-frame. A change to them at any later point in that frame, in either half, appears only in the following frame.
- R10: With `isMaster`=0, framing follows `bclkIn` and `lrckIn`, each high or low for at least 4 `clk2x` cycles, for both 32 and 64 bit-clock periods per half-frame. `bclkOut` and `lrckOut` stay 0 in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Core clock, twice the master-clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| speedSel | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 as single |
| mdivEn | input | 1 | Halve the master clock before division (master mode only) |
| isMaster | input | 1 | 1: generate clocks, 0: follow external clocks |
| fmtI2s | input | 1 | 0: left-justified framing, 1: I2S framing |
| bclkIn | input | 1 | External bit clock (slave mode) |
| lrckIn | input | 1 | External frame clock (slave mode) |
| leftIn | input | 24 | Left sample, two's complement |
| rightIn | input | 24 | Right sample, two's complement |
| sdata | output | 1 | Serial data |
| bclkOut | output | 1 | Generated bit clock (0 in slave mode) |
| lrckOut | output | 1 | Generated frame clock (0 in slave mode) |

## Verification
Suppose the slot counter or the remembered frame level is wrong. The framing then shifts, and within one frame the decoded words come out rotated, with non-zero bits in padding slots. Suppose instead the clock-divider index is wrong for some speed or prescale setting. Then the bit-clock and frame-clock periods measured at the ports are off by a power of two from the first period onward. A capture made at the wrong moment shows up as a frame that mixes old and new sample values, seen on the frame in which the inputs change.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  // Strobes from clock control to the slot shifter
  typedef struct packed {
    logic bitFall;   // a bit-clock falling edge happens at this clock edge
    logic lrLevel;   // frame-clock level in effect after that edge
  } slot_stb_t;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  // Number of halvings removed from the slowest division; reserved maps to single
  function automatic int speedShift(input logic [1:0] code);
    case (speed_e'(code))
      SPD_DOUBLE: speedShift = 1;
      SPD_QUAD:   speedShift = 2;
      default:    speedShift = 0;
    endcase
  endfunction

endpackage

// File: rtl/aud_clk_ctrl.sv
module aud_clk_ctrl
  import aud_tx_pkg::*;
#(
  parameter int HALF_SLOTS = 32,
  parameter int SYNC_LEN   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       isMaster,
  input  logic [1:0] speedSel,
  input  logic       mdivEn,
  input  logic       bclkIn,
  input  logic       lrckIn,
  output slot_stb_t  stb,
  output logic       bclkOut,
  output logic       lrckOut
);

  localparam int HALF_LOG = $clog2(HALF_SLOTS);
  // largest bit-clock half-period exponent is 3 (single speed, prescaled)
  localparam int PH_W  = HALF_LOG + 5;
  localparam int IDX_W = $clog2(PH_W);

  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  phaseNext;
  logic [IDX_W-1:0] idxB;
  logic [IDX_W-1:0] idxL;
  int               kB;

  always_comb begin
    kB        = 2 - speedShift(speedSel) + int'(mdivEn);
    idxB      = IDX_W'(kB);
    idxL      = IDX_W'(kB + 1 + HALF_LOG);
    phaseNext = phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else       phase <= phaseNext;
  end

  // Slave clock synchronisers
  logic [SYNC_LEN:0]   bSync;
  logic [SYNC_LEN-1:0] lSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      lSync <= '0;
    end else begin
      bSync <= {bSync[SYNC_LEN-1:0], bclkIn};
      lSync <= {lSync[SYNC_LEN-2:0], lrckIn};
    end
  end

  logic masterFall;
  logic slaveFall;

  always_comb begin
    masterFall = phase[idxB] & ~phaseNext[idxB];
    slaveFall  = bSync[SYNC_LEN] & ~bSync[SYNC_LEN-1];
    stb.bitFall = isMaster ? masterFall : slaveFall;
    stb.lrLevel = isMaster ? phaseNext[idxL] : lSync[SYNC_LEN-1];
  end

  assign bclkOut = isMaster & phase[idxB];
  assign lrckOut = isMaster & phase[idxL];

  // Checker: bit-clock falls counted inside each generated half-frame
  logic [HALF_LOG:0] fallCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !isMaster) fallCnt <= '0;
    else if (stb.bitFall) begin
      if (stb.lrLevel != lrckOut) fallCnt <= '0;
      else                        fallCnt <= fallCnt + 1'b1;
    end
  end

  assert_lr_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && $past(isMaster) && (lrckOut != $past(lrckOut))) |-> $fell(bclkOut));

  assert_half_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && stb.bitFall && (stb.lrLevel != lrckOut))
      |-> (fallCnt == (HALF_LOG+1)'(HALF_SLOTS - 1)));

endmodule

// File: rtl/aud_shift_dp.sv
module aud_shift_dp
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int MAX_HALF = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fmtI2s,
  input  slot_stb_t           stb,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                sdata
);

  localparam int SLOT_W = $clog2(MAX_HALF);
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(MAX_HALF - 1);

  logic                lrPrev;
  logic [SLOT_W-1:0]   slot;
  logic [SAMPLE_W-1:0] heldL;
  logic [SAMPLE_W-1:0] heldR;

  logic                newHalf;
  logic                leftSide;
  logic                capture;
  logic [SLOT_W-1:0]   slotNext;
  logic [SAMPLE_W-1:0] wordNow;
  logic                bitNext;
  int                  pos;

  always_comb begin
    newHalf  = stb.lrLevel != lrPrev;
    leftSide = stb.lrLevel ^ fmtI2s;          // LJ: high is left, I2S: low is left
    capture  = stb.bitFall & newHalf & leftSide;
    if (newHalf)               slotNext = '0;
    else if (slot == SLOT_MAX) slotNext = slot;
    else                       slotNext = slot + 1'b1;
    wordNow  = leftSide ? (capture ? leftIn : heldL) : heldR;
    pos      = int'(slotNext) - int'(fmtI2s);
    bitNext  = 1'b0;
    if (pos >= 0 && pos < SAMPLE_W) bitNext = wordNow[SAMPLE_W-1-pos];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lrPrev <= 1'b0;
      slot   <= '0;
      heldL  <= '0;
      heldR  <= '0;
      sdata  <= 1'b0;
    end else if (stb.bitFall) begin
      lrPrev <= stb.lrLevel;
      slot   <= slotNext;
      sdata  <= bitNext;
      if (capture) begin
        heldL <= leftIn;
        heldR <= rightIn;
      end
    end
  end

  assert_sdata_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sdata != $past(sdata)) |-> $past(stb.bitFall));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.bitFall) |-> (heldL == $past(heldL) && heldR == $past(heldR)));

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int HALF_SLOTS = 32,
  parameter int MAX_HALF   = 64
) (
  input  logic                clk2x,
  input  logic                rstN,
  input  logic [1:0]          speedSel,
  input  logic                mdivEn,
  input  logic                isMaster,
  input  logic                fmtI2s,
  input  logic                bclkIn,
  input  logic                lrckIn,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                sdata,
  output logic                bclkOut,
  output logic                lrckOut
);

  slot_stb_t stb;

  aud_clk_ctrl #(
    .HALF_SLOTS(HALF_SLOTS),
    .SYNC_LEN  (2)
  ) u_ctrl (
    .clk     (clk2x),
    .rstN    (rstN),
    .isMaster(isMaster),
    .speedSel(speedSel),
    .mdivEn  (mdivEn),
    .bclkIn  (bclkIn),
    .lrckIn  (lrckIn),
    .stb     (stb),
    .bclkOut (bclkOut),
    .lrckOut (lrckOut)
  );

  aud_shift_dp #(
    .SAMPLE_W(SAMPLE_W),
    .MAX_HALF(MAX_HALF)
  ) u_dp (
    .clk    (clk2x),
    .rstN   (rstN),
    .fmtI2s (fmtI2s),
    .stb    (stb),
    .leftIn (leftIn),
    .rightIn(rightIn),
    .sdata  (sdata)
  );

endmodule

// File: tb/aud_serial_tx_tb.sv
`timescale 1ns/1ps
module aud_serial_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SLV_H      = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  speedSel = 2'b00;
  logic        mdivEn = 1'b0;
  logic        isMaster = 1'b1;
  logic        fmtI2s = 1'b0;
  logic        bclkIn, lrckIn;
  logic [23:0] leftIn = '0, rightIn = '0;
  logic        sdata, bclkOut, lrckOut;
  logic        bclkW, lrckW;

  int total = 0;
  int bad   = 0;
  bit slvRun = 0;
  int slvHalf = 32;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_serial_tx u_dut (
    .clk2x(clk), .rstN(rstN), .speedSel(speedSel), .mdivEn(mdivEn),
    .isMaster(isMaster), .fmtI2s(fmtI2s), .bclkIn(bclkIn), .lrckIn(lrckIn),
    .leftIn(leftIn), .rightIn(rightIn), .sdata(sdata),
    .bclkOut(bclkOut), .lrckOut(lrckOut)
  );

  assign bclkW = isMaster ? bclkOut : bclkIn;
  assign lrckW = isMaster ? lrckOut : lrckIn;

  // External clock source for slave mode; frame clock moves with bit-clock falls
  initial begin
    int ph = 0;
    int sl = 0;
    bclkIn = 1'b0;
    lrckIn = 1'b0;
    forever begin
      @(negedge clk);
      if (!slvRun) begin
        ph = 0; sl = 0; bclkIn = 1'b0; lrckIn = 1'b0;
      end else begin
        ph++;
        if (ph == SLV_H) begin
          ph = 0;
          if (bclkIn) begin
            bclkIn = 1'b0;
            sl++;
            if (sl == slvHalf) begin sl = 0; lrckIn = ~lrckIn; end
          end else bclkIn = 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setup(input bit master, input logic [1:0] spd, input logic dv,
                       input logic fmt, input logic [23:0] l, input logic [23:0] r);
    slvRun = 0;
    rstN = 1'b0;
    isMaster = master; speedSel = spd; mdivEn = dv; fmtI2s = fmt;
    leftIn = l; rightIn = r;
    repeat (4) @(negedge clk);
    chk(!sdata && !bclkOut && !lrckOut, "R1", "outputs in reset",
        {bclkOut, lrckOut, sdata}, 0);
    rstN = 1'b1;
    slvRun = !master;
  endtask

  task automatic period(input bit useLr, output int n);
    logic p, c;
    bit seen = 0;
    bit done = 0;
    int cnt = 0;
    p = useLr ? lrckW : bclkW;
    while (!done) begin
      @(negedge clk);
      c = useLr ? lrckW : bclkW;
      if (seen) cnt++;
      if (c && !p) begin
        if (seen) done = 1;
        else seen = 1;
      end
      p = c;
    end
    n = cnt;
  endtask

  // Receive one frame starting at a left half-frame; optionally change inputs at a slot
  task automatic getFrame(input logic fmt, input int halfSlots, input int changeAt,
                          input logic [23:0] nl, input logic [23:0] nr,
                          output logic [23:0] gl, output logic [23:0] gr,
                          output int padErr, output int clkErr);
    logic [0:127] bits;
    logic [0:127] lrs;
    logic pb, lastLr, leftLv;
    bit have = 0;
    bit started = 0;
    int slot = 0;
    int off;
    leftLv = fmt ? 1'b0 : 1'b1;
    off = fmt ? 1 : 0;
    pb = bclkW; lastLr = 1'b0;
    gl = '0; gr = '0; padErr = 0; clkErr = 0;
    bits = '0; lrs = '0;
    while (slot < 2*halfSlots) begin
      @(negedge clk);
      if (!isMaster && (bclkOut || lrckOut)) clkErr++;
      if (bclkW && !pb) begin
        if (!started) begin
          if (have && lrckW == leftLv && lastLr != leftLv) started = 1;
          lastLr = lrckW; have = 1;
        end
        if (started) begin
          bits[slot] = sdata;
          lrs[slot]  = lrckW;
          if (slot == changeAt) begin leftIn = nl; rightIn = nr; end
          slot++;
        end
      end
      pb = bclkW;
    end
    for (int j = 0; j < 24; j++) begin
      gl[23-j] = bits[off+j];
      gr[23-j] = bits[halfSlots+off+j];
    end
    for (int i = 0; i < 2*halfSlots; i++) begin
      int p2;
      p2 = i % halfSlots;
      if ((p2 < off || p2 >= off + 24) && bits[i]) padErr++;
      if (lrs[i] != ((i < halfSlots) ? leftLv : ~leftLv)) clkErr++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] lv, rv, gl, gr, l2, r2;
    int bp, lp, pe, ce, k, s;
    string fmtTag, bTag;

    // Master sweep over speed code, prescaler and format
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic [1:0] spd;
      logic dv, fm;
      spd = cfg[1:0]; dv = cfg[2]; fm = cfg[3];
      lv = 24'((cfg + 1) * 24'h13579B) ^ 24'h800001;
      rv = 24'((cfg + 3) * 24'h2468AD) ^ 24'h0F00F1;
      s  = (spd == 2'b10) ? 2 : (spd == 2'b01) ? 1 : 0;
      k  = 2 - s + int'(dv);
      fmtTag = fm ? "R5 R7" : "R5 R6";
      bTag   = dv ? "R4 bit period" : "R3 bit period";
      setup(1'b1, spd, dv, fm, lv, rv);
      period(1'b0, bp);
      chk(bp == (2 << k), bTag, "bclk cycles", bp, 2 << k);
      period(1'b1, lp);
      chk(lp == (128 << k), dv ? "R2 R4 frame period" : "R2 frame period",
          "lrck cycles", lp, 128 << k);
      getFrame(fm, 32, -1, lv, rv, gl, gr, pe, ce);
      chk(gl == lv, fmtTag, "left word", gl, lv);
      chk(gr == rv, fmtTag, "right word", gr, rv);
      chk(pe == 0, "R8", "nonzero pad slots", pe, 0);
      chk(ce == 0, fm ? "R7 R3" : "R6 R3", "frame level per half", ce, 0);
    end

    // Capture point: changes inside a frame wait for the next one
    for (int f = 0; f < 2; f++) begin
      lv = 24'hC0FFEE; rv = 24'h123456;
      l2 = 24'h3A5A5A; r2 = 24'hFEDCBA;
      setup(1'b1, 2'b01, 1'b0, f[0], lv, rv);
      getFrame(f[0], 32, f ? 40 : 5, l2, r2, gl, gr, pe, ce);
      chk(gl == lv && gr == rv, "R9", "frame with mid-frame change",
          {gl, gr}, {lv, rv});
      getFrame(f[0], 32, -1, l2, r2, gl, gr, pe, ce);
      chk(gl == l2 && gr == r2, "R9", "following frame", {gl, gr}, {l2, r2});
    end

    // Slave mode, 64 and 128 bit clocks per frame, both formats
    for (int c = 0; c < 4; c++) begin
      logic fm;
      fm = c[0];
      slvHalf = c[1] ? 64 : 32;
      lv = 24'h7FFFFF ^ 24'(c * 24'h111111);
      rv = 24'h800000 | 24'(c * 24'h0A0B0C);
      setup(1'b0, 2'b00, 1'b0, fm, lv, rv);
      getFrame(fm, slvHalf, -1, lv, rv, gl, gr, pe, ce);
      chk(gl == lv && gr == rv, fm ? "R10 R7" : "R10 R6", "slave words",
          {gl, gr}, {lv, rv});
      chk(pe == 0, "R10 R8", "slave pad slots", pe, 0);
      chk(ce == 0, "R10", "slave clock outputs and levels", ce, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule